// File: doc/BRIEF.md
# Three-Mode Carrier Phase Recovery Loop

This block tracks the carrier phase and frequency of a 64-QAM receiver. It uses one loop whose phase-error law changes as the equalizer settles. After a start pulse the loop is in acquisition. Its error comes from the raw received sample through a sign-based Costas law, which needs no symbol decisions. When the equalizer flags rough convergence, the loop moves to tracking. It then uses a decision-directed maximum-likelihood error built on a 64-QAM slicer. When the equalizer flags full convergence, the loop moves to steady state with a decision-directed minimum-MSE error.

A proportional-integral filter with power-of-two gains drives a phase accumulator (the NCO). Each mode has its own pair of gain shifts. During acquisition a leaky integrator follows the filter output to estimate its DC level, which is the frequency offset learned so far. On the move to tracking, that estimate is frozen and added to the NCO's base frequency word. The integrator is cleared at the same moment, so the offset is not counted twice. Sine/cosine generation and derotation happen outside this block, which supplies only the phase word.

Top module: `carrier_track`

## Requirements
- R1: On reset or on a cycle with `startPulse` high, the next state is: mode 0, phase word 0, phase error 0, loop integrator 0, DC estimate 0, and frequency word = `BASE_FREQ`. With zero phase error, the phase word then advances by exactly `BASE_FREQ` per cycle.
- R2: The slicer maps each axis to the nearest odd multiple of 2^`UNIT_SH` in ±1, ±3, ±5, ±7 (256 to 1792 by default). A value exactly on a boundary goes to the upper level (0 maps to +256, -1 maps to -256).
- R3: In mode 0 (acquisition) the phase error is sgn(rxQ)·rxI − sgn(rxI)·rxQ, with sgn(v) = −1 for v < 0 and +1 otherwise. It is registered and appears one cycle after the sample.
- R4: In mode 1 (tracking) the phase error is (dQ·eqI − dI·eqQ) >>> `UNIT_SH`, where dI and dQ are the slicer decisions of eqI and eqQ. It appears one cycle after the sample.
- R5: In mode 2 (steady state) the phase error is eI·sgn(eqQ) − eQ·sgn(eqI), where eI = eqI − dI and eQ = eqQ − dQ. It appears one cycle after the sample.
- R6: Mode encoding is 0 = acquisition, 1 = tracking, 2 = steady. Mode 0 moves to 1 on `roughConv`, and mode 1 moves to 2 on `fullConv`. A mode never goes backward except through `startPulse`, and it never skips a step: `fullConv` has no effect in mode 0.
- R7: Each cycle the filter output is (err >>> KP) + integrator, and the integrator then adds err >>> KI. KP and KI are chosen by the current mode. Both are 24-bit wrap-around values.
- R8: Each cycle the phase word takes phase + frequency word + filter output, modulo 2^24.
- R9: In mode 0 the DC estimate updates as dc += (filt − dc) >>> 8. On the cycle that leaves mode 0, the frequency word becomes `BASE_FREQ` + dc and the integrator is cleared. From then on, dc is no longer updated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| startPulse | input | 1 | Synchronous restart into acquisition |
| roughConv | input | 1 | Equalizer rough-convergence flag |
| fullConv | input | 1 | Equalizer full-convergence flag |
| eqI | input | W | Equalized sample, in-phase |
| eqQ | input | W | Equalized sample, quadrature |
| rxI | input | W | Received sample, in-phase |
| rxQ | input | W | Received sample, quadrature |
| phaseWord | output | ACC_W | NCO phase accumulator |
| modeOut | output | 2 | Current operating mode |
| phErr | output | ERR_W | Registered phase error |

## Verification
The checker watches the mode sequence on every cycle. It checks that the mode never goes backward, never skips tracking, follows each convergence flag at the next edge, and clears phase and error after a start pulse. Whether the three error laws, the slicer levels, the PI arithmetic and the frequency handover are numerically right cannot be seen from the mode alone. The bench's reference model covers these by comparing every cycle. It also runs directed vectors for the slicer edges and measures the phase step just after handover.

// File: rtl/crl_pkg.sv
package crl_pkg;
  typedef enum logic [1:0] {
    MODE_ACQ = 2'd0,
    MODE_TRK = 2'd1,
    MODE_SS  = 2'd2
  } crl_mode_e;

  typedef struct packed {
    logic clearAll;
    logic handover;
    logic dcEn;
  } crl_strobe_t;
endpackage

// File: rtl/crl_slicer.sv
module crl_slicer #(
  parameter int W       = 12,
  parameter int UNIT_SH = 8
) (
  input  logic signed [W-1:0] sample,
  output logic signed [W-1:0] level
);
  localparam logic signed [W-1:0] IDX_HI = 3;
  localparam logic signed [W-1:0] IDX_LO = -4;

  logic signed [W-1:0] idxFull;
  logic signed [4:0]   oddC;
  logic signed [W-1:0] oddExt;

  always_comb begin
    idxFull = sample >>> (UNIT_SH + 1);
    if (idxFull > IDX_HI)      oddC = 5'sd7;
    else if (idxFull < IDX_LO) oddC = -5'sd7;
    else                       oddC = {idxFull[3:0], 1'b1};
    oddExt = W'(oddC);
    level  = oddExt <<< UNIT_SH;
  end
endmodule

// File: rtl/crl_ctrl.sv
module crl_ctrl
  import crl_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        startPulse,
  input  logic        roughConv,
  input  logic        fullConv,
  output crl_mode_e   mode,
  output crl_strobe_t strobes
);
  always_comb begin
    strobes.clearAll = startPulse;
    strobes.handover = !startPulse && (mode == MODE_ACQ) && roughConv;
    strobes.dcEn     = !startPulse && (mode == MODE_ACQ) && !roughConv;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode <= MODE_ACQ;
    end else if (startPulse) begin
      mode <= MODE_ACQ;
    end else begin
      case (mode)
        MODE_ACQ: if (roughConv) mode <= MODE_TRK;
        MODE_TRK: if (fullConv)  mode <= MODE_SS;
        default:  mode <= MODE_SS;
      endcase
    end
  end
endmodule

// File: rtl/crl_dp.sv
module crl_dp
  import crl_pkg::*;
#(
  parameter int W       = 12,
  parameter int UNIT_SH = 8,
  parameter int ERR_W   = 16,
  parameter int ACC_W   = 24,
  parameter int DC_SH   = 8,
  parameter logic [ACC_W-1:0] BASE_FREQ = 24'h0A3D71,
  parameter int KP_ACQ = 2,
  parameter int KI_ACQ = 8,
  parameter int KP_TRK = 3,
  parameter int KI_TRK = 9,
  parameter int KP_SS  = 4,
  parameter int KI_SS  = 11
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  crl_mode_e               mode,
  input  crl_strobe_t             strobes,
  input  logic signed [W-1:0]     eqI,
  input  logic signed [W-1:0]     eqQ,
  input  logic signed [W-1:0]     rxI,
  input  logic signed [W-1:0]     rxQ,
  output logic [ACC_W-1:0]        phaseWord,
  output logic signed [ERR_W-1:0] phErr
);
  localparam int PW = 2 * W + 2;

  logic signed [W-1:0] eqAx [2];
  logic signed [W-1:0] decAx [2];

  assign eqAx[0] = eqI;
  assign eqAx[1] = eqQ;

  for (genvar ax = 0; ax < 2; ax++) begin : g_axis
    crl_slicer #(.W(W), .UNIT_SH(UNIT_SH)) u_slice (
      .sample(eqAx[ax]),
      .level (decAx[ax])
    );
  end

  logic signed [PW-1:0] rxIx, rxQx, eqIx, eqQx, decIx, decQx, resIx, resQx;
  logic signed [ERR_W-1:0] errNow;
  logic signed [ACC_W-1:0] errExt, filt, integ, dcEst, dcNext;
  logic signed [ACC_W:0]   dcDiff;
  logic [ACC_W-1:0]        phaseAcc, freqWord;
  int unsigned             kpSel, kiSel;

  always_comb begin
    rxIx  = PW'(rxI);
    rxQx  = PW'(rxQ);
    eqIx  = PW'(eqI);
    eqQx  = PW'(eqQ);
    decIx = PW'(decAx[0]);
    decQx = PW'(decAx[1]);
    resIx = eqIx - decIx;
    resQx = eqQx - decQx;
    case (mode)
      MODE_ACQ: begin
        errNow = ERR_W'((rxQ[W-1] ? -rxIx : rxIx) - (rxI[W-1] ? -rxQx : rxQx));
        kpSel  = KP_ACQ;
        kiSel  = KI_ACQ;
      end
      MODE_TRK: begin
        errNow = ERR_W'((decQx * eqIx - decIx * eqQx) >>> UNIT_SH);
        kpSel  = KP_TRK;
        kiSel  = KI_TRK;
      end
      default: begin
        errNow = ERR_W'((eqQ[W-1] ? -resIx : resIx) - (eqI[W-1] ? -resQx : resQx));
        kpSel  = KP_SS;
        kiSel  = KI_SS;
      end
    endcase
    errExt = ACC_W'(errNow);
    filt   = (errExt >>> kpSel) + integ;
    dcDiff = {filt[ACC_W-1], filt} - {dcEst[ACC_W-1], dcEst};
    dcNext = dcEst + ACC_W'(dcDiff >>> DC_SH);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phaseAcc <= '0;
      freqWord <= BASE_FREQ;
      integ    <= '0;
      dcEst    <= '0;
      phErr    <= '0;
    end else if (strobes.clearAll) begin
      phaseAcc <= '0;
      freqWord <= BASE_FREQ;
      integ    <= '0;
      dcEst    <= '0;
      phErr    <= '0;
    end else begin
      phErr    <= errNow;
      phaseAcc <= phaseAcc + freqWord + filt;
      if (strobes.handover) begin
        freqWord <= BASE_FREQ + dcEst;
        integ    <= '0;
      end else begin
        integ <= integ + (errExt >>> kiSel);
      end
      if (strobes.dcEn) dcEst <= dcNext;
    end
  end

  assign phaseWord = phaseAcc;
endmodule

// File: rtl/carrier_track.sv
module carrier_track
  import crl_pkg::*;
#(
  parameter int W       = 12,
  parameter int UNIT_SH = 8,
  parameter int ERR_W   = 16,
  parameter int ACC_W   = 24,
  parameter int DC_SH   = 8,
  parameter logic [ACC_W-1:0] BASE_FREQ = 24'h0A3D71,
  parameter int KP_ACQ = 2,
  parameter int KI_ACQ = 8,
  parameter int KP_TRK = 3,
  parameter int KI_TRK = 9,
  parameter int KP_SS  = 4,
  parameter int KI_SS  = 11
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    startPulse,
  input  logic                    roughConv,
  input  logic                    fullConv,
  input  logic signed [W-1:0]     eqI,
  input  logic signed [W-1:0]     eqQ,
  input  logic signed [W-1:0]     rxI,
  input  logic signed [W-1:0]     rxQ,
  output logic [ACC_W-1:0]        phaseWord,
  output logic [1:0]              modeOut,
  output logic signed [ERR_W-1:0] phErr
);
  crl_mode_e   mode;
  crl_strobe_t strobes;

  crl_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .startPulse(startPulse),
    .roughConv (roughConv),
    .fullConv  (fullConv),
    .mode      (mode),
    .strobes   (strobes)
  );

  crl_dp #(
    .W(W), .UNIT_SH(UNIT_SH), .ERR_W(ERR_W), .ACC_W(ACC_W), .DC_SH(DC_SH),
    .BASE_FREQ(BASE_FREQ),
    .KP_ACQ(KP_ACQ), .KI_ACQ(KI_ACQ), .KP_TRK(KP_TRK), .KI_TRK(KI_TRK),
    .KP_SS(KP_SS), .KI_SS(KI_SS)
  ) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode     (mode),
    .strobes  (strobes),
    .eqI      (eqI),
    .eqQ      (eqQ),
    .rxI      (rxI),
    .rxQ      (rxQ),
    .phaseWord(phaseWord),
    .phErr    (phErr)
  );

  assign modeOut = mode;
endmodule

// File: rtl/carrier_track_chk.sv
module carrier_track_chk #(
  parameter int ACC_W = 24,
  parameter int ERR_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             startPulse,
  input logic             roughConv,
  input logic             fullConv,
  input logic [ACC_W-1:0] phaseWord,
  input logic [1:0]       modeOut,
  input logic [ERR_W-1:0] phErr
);
  a_r6_mode_legal: assert property (@(posedge clk) disable iff (!rst_n)
    modeOut != 2'd3);

  a_r6_forward_only: assert property (@(posedge clk) disable iff (!rst_n)
    !startPulse |=> modeOut >= $past(modeOut));

  a_r6_no_skip: assert property (@(posedge clk) disable iff (!rst_n)
    (modeOut == 2'd0 && !startPulse) |=> modeOut != 2'd2);

  a_r6_acq_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (modeOut == 2'd0 && roughConv && !startPulse) |=> modeOut == 2'd1);

  a_r6_trk_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (modeOut == 2'd1 && fullConv && !startPulse) |=> modeOut == 2'd2);

  a_r1_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    startPulse |=> (modeOut == 2'd0 && phaseWord == '0 && phErr == '0));
endmodule

bind carrier_track carrier_track_chk #(.ACC_W(ACC_W), .ERR_W(ERR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .startPulse(startPulse),
  .roughConv (roughConv),
  .fullConv  (fullConv),
  .phaseWord (phaseWord),
  .modeOut   (modeOut),
  .phErr     (phErr)
);

// File: tb/carrier_track_bench.sv
`timescale 1ns/1ps
module carrier_track_bench;
  localparam int W = 12;
  localparam int ACC_W = 24;
  localparam int ERR_W = 16;
  localparam int BASE = 32'h0A3D71;
  localparam int MASK = 32'h00FFFFFF;
  localparam int KP [3] = '{2, 3, 4};
  localparam int KI [3] = '{8, 9, 11};

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, startPulse, roughConv, fullConv;
  logic signed [W-1:0] eqI, eqQ, rxI, rxQ;
  logic [ACC_W-1:0] phaseWord;
  logic [1:0] modeOut;
  logic signed [ERR_W-1:0] phErr;

  carrier_track #(.BASE_FREQ(24'h0A3D71)) u_carrier_track (
    .clk(clk), .rst_n(rst_n), .startPulse(startPulse),
    .roughConv(roughConv), .fullConv(fullConv),
    .eqI(eqI), .eqQ(eqQ), .rxI(rxI), .rxQ(rxQ),
    .phaseWord(phaseWord), .modeOut(modeOut), .phErr(phErr)
  );

  int checks = 0, fails = 0;
  bit done = 0;
  int mMode, mInteg, mDc, mFreq, mPhase, mErr;
  int unsigned seed = 32'h1234_5678;

  function automatic int w24(int x);
    return ((x & MASK) ^ 32'h800000) - 32'h800000;
  endfunction

  function automatic int sgn(int v);
    return (v < 0) ? -1 : 1;
  endfunction

  function automatic int slc(int v);
    int idx;
    idx = v >>> 9;
    if (idx > 3) idx = 3;
    if (idx < -4) idx = -4;
    return (2 * idx + 1) * 256;
  endfunction

  function automatic int rnd();
    seed = seed * 1103515245 + 12345;
    return int'($signed(seed[27:16]));
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic modelReset();
    mMode = 0; mInteg = 0; mDc = 0; mFreq = BASE; mPhase = 0; mErr = 0;
  endtask

  task automatic modelStep(int yI, int yQ, int rI, int rQ, bit st, bit rough, bit full);
    int err, filt, eI, eQ;
    if (st) begin
      modelReset();
      return;
    end
    case (mMode)
      0: err = sgn(rQ) * rI - sgn(rI) * rQ;
      1: err = (slc(yQ) * yI - slc(yI) * yQ) >>> 8;
      default: begin
        eI = yI - slc(yI);
        eQ = yQ - slc(yQ);
        err = eI * sgn(yQ) - eQ * sgn(yI);
      end
    endcase
    filt = w24((err >>> KP[mMode]) + mInteg);
    mPhase = (mPhase + mFreq + filt) & MASK;
    mErr = err;
    if (mMode == 0 && rough) begin
      mFreq = w24(BASE + mDc);
      mInteg = 0;
      mMode = 1;
    end else begin
      mInteg = w24(mInteg + (err >>> KI[mMode]));
      if (mMode == 0) mDc = w24(mDc + ((filt - mDc) >>> 8));
      else if (mMode == 1 && full) mMode = 2;
    end
  endtask

  task automatic step(int yI, int yQ, int rI, int rQ, bit st, bit rough, bit full);
    string errTag;
    errTag = st ? "R1" : (mMode == 0) ? "R3" : (mMode == 1) ? "R4" : "R5";
    eqI = W'(yI); eqQ = W'(yQ); rxI = W'(rI); rxQ = W'(rQ);
    startPulse = st; roughConv = rough; fullConv = full;
    modelStep(yI, yQ, rI, rQ, st, rough, full);
    @(posedge clk);
    @(negedge clk);
    check("R6 mode", int'(modeOut), mMode);
    check({errTag, " phase error"}, int'(phErr), mErr);
    check("R7 R8 phase", int'(phaseWord), mPhase);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int p0, p1, dcFrozen;
    rst_n = 0; startPulse = 0; roughConv = 0; fullConv = 0;
    eqI = '0; eqQ = '0; rxI = '0; rxQ = '0;
    modelReset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    check("R1 reset mode", int'(modeOut), 0);
    check("R1 reset phase", int'(phaseWord), 0);
    check("R1 reset error", int'(phErr), 0);
    step(0, 0, 0, 0, 0, 0, 0);
    check("R1 base step", int'(phaseWord), BASE);

    // Acquisition with noise; fullConv toggling must be ignored (R6)
    for (int i = 0; i < 300; i++) begin
      int a, b;
      a = rnd(); b = rnd();
      step(rnd(), rnd(), a, b, 0, 0, (i % 3) == 0);
    end
    check("R6 fullConv ignored in acquisition", int'(modeOut), 0);

    // Handover into tracking (R9)
    step(rnd(), rnd(), 700, -300, 0, 1, 0);
    check("R6 rough moves to tracking", int'(modeOut), 1);
    dcFrozen = mDc;
    p0 = int'(phaseWord);
    step(256, 256, 0, 0, 0, 0, 0);
    p1 = int'(phaseWord);
    check("R9 first step after handover", (p1 - p0) & MASK, (BASE + dcFrozen) & MASK);
    step(256, 256, 0, 0, 0, 1, 0);
    check("R9 offset held, integrator clear", (int'(phaseWord) - p1) & MASK,
          (BASE + dcFrozen) & MASK);

    // Slicer and tracking law (R2, R4)
    step(300, 0, 0, 0, 0, 0, 0);
    check("R2 R4 slicer zero region", int'(phErr), 300);
    step(2047, -2048, 0, 0, 0, 0, 0);
    check("R2 R4 slicer outer levels", int'(phErr), 7);
    step(-1, 600, 0, 0, 0, 0, 0);
    check("R2 R4 slicer negative boundary", int'(phErr), 597);

    for (int i = 0; i < 200; i++) step(rnd(), rnd(), rnd(), rnd(), 0, (i % 2) == 0, 0);
    check("R6 still tracking", int'(modeOut), 1);

    step(rnd(), rnd(), 0, 0, 0, 0, 1);
    check("R6 full moves to steady", int'(modeOut), 2);
    step(300, 100, 0, 0, 0, 0, 0);
    check("R5 steady error", int'(phErr), 200);
    for (int i = 0; i < 200; i++) step(rnd(), rnd(), rnd(), rnd(), 0, (i % 2) == 1, (i % 3) == 1);
    check("R6 steady holds", int'(modeOut), 2);

    // Restart (R1) and acquisition law (R3)
    step(rnd(), rnd(), rnd(), rnd(), 1, 1, 1);
    check("R1 start mode", int'(modeOut), 0);
    check("R1 start phase", int'(phaseWord), 0);
    step(0, 0, 100, -50, 0, 0, 0);
    check("R3 costas error", int'(phErr), -50);
    step(0, 0, -7, 20, 0, 0, 0);
    check("R3 costas error negative I", int'(phErr), 13);
    for (int i = 0; i < 100; i++) step(rnd(), rnd(), rnd(), rnd(), 0, i == 60, i > 80);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule